// File: doc/BRIEF.md
# Peripheral Power-Up Sequencer

This block brings one peripheral out of its off state in a safe order. An enable request places the peripheral in reset, waits a first settling interval with the clock still stopped, starts the clock, waits a second and longer interval so the clock can settle, and only then lets the peripheral out of reset. A disable request stops the clock and leaves the reset line exactly where it is. The peripheral counts as enabled only while its clock runs and its reset is released. A peripheral held in reset therefore never counts as enabled, even with its clock running.

A build-time switch says whether the peripheral has a reset line at all. Without one, the reset output stays low and an enable request only starts the clock, with no waits. Both settling intervals are parameters counted in clock cycles. The defaults are about 100 µs and 10 ms at 200 MHz, and a test can set them much shorter. The block shows busy while a sequence runs and pulses done for one cycle each time a request completes. An enable request that arrives during a sequence is dropped. A disable request that arrives during a sequence is kept and carried out once the sequence ends.

States: `SEQ_IDLE` (waits for requests; single-cycle requests complete here), `SEQ_PRE` (reset held, clock stopped, first wait) and `SEQ_POST` (reset held, clock running, second wait). Transitions: `SEQ_IDLE -> SEQ_PRE` on an accepted enable while the peripheral is off and a reset line exists. `SEQ_PRE -> SEQ_POST` when the first wait expires, which also starts the clock. `SEQ_POST -> SEQ_IDLE` when the second wait expires, which also releases reset and pulses done.

Top module: `periph_power_seq`

## Requirements
- R1: After power-on reset the clock enable is 0, busy, done and enabled are 0, and the reset output is 1 when a reset line exists.
- R2: When an enable request is accepted in cycle 0 with a reset line present and the peripheral off, the reset output is 1 from cycle 0. The clock enable rises in cycle PRE_CYC. The reset output falls in cycle PRE_CYC+POST_CYC while the clock enable stays 1. This also applies when the peripheral was enabled before and then disabled.
- R3: Busy is 1 in cycles 0 through PRE_CYC+POST_CYC-1 of a sequence. Done is 1 only in cycle PRE_CYC+POST_CYC, and busy is 0 in that cycle.
- R4: Enabled is 1 exactly when the clock enable is 1 and the reset output is 0. In particular it is 0 during the second wait, while the clock runs under reset.
- R5: An enable request while the peripheral is already enabled pulses done in the next cycle and changes neither the clock enable nor the reset output. Busy stays 0.
- R6: A disable request in idle drives the clock enable to 0 in the next cycle and pulses done. The reset output keeps its value.
- R7: Enable requests that arrive while busy have no effect. The running sequence ends on time and no second sequence follows.
- R8: A disable request that arrives while busy is held. The sequence completes normally, and in the next cycle the clock enable goes to 0 with a second done pulse.
- R9: With no reset line, the reset output and busy stay 0. An enable request sets the clock enable and pulses done in the next cycle.
- R10: When enable and disable requests arrive together in idle, the disable request is taken and the enable request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enable_req_i | input | 1 | Request to turn the peripheral on (sampled per cycle) |
| disable_req_i | input | 1 | Request to stop the peripheral clock (sampled per cycle) |
| clk_en_o | output | 1 | Clock enable toward the peripheral clock gate |
| periph_rst_o | output | 1 | Reset toward the peripheral, active high |
| busy_o | output | 1 | A power-up sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| enabled_o | output | 1 | Peripheral clock running and reset released |

## Verification
The assertions check the ordering rules on every cycle. The clock may only start while reset is held. Reset may only be released with the clock running, and only after exactly POST_CYC cycles of clock under reset. A disable never moves the reset line. Busy implies reset. Done and busy are never high together, and a part without a reset line never shows reset or busy. The exact start cycle of the clock, the dropping of enable requests during a sequence, the deferred disable, the priority between simultaneous requests and the quick completion for an already enabled peripheral depend on request history. Only the bench's directed scenarios show those.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PRE  = 2'd1,
        SEQ_POST = 2'd2
    } seq_state_t;

endpackage

// File: rtl/psq_wait_timer.sv
// Single-shot down counter: expired_o is high in the LEN-th cycle after start_i.
module psq_wait_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/psq_pend_hold.sv
// Holds a disable request seen during a sequence until the idle state takes it.
module psq_pend_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end
    end
endmodule

// File: rtl/periph_power_seq.sv
module periph_power_seq
    import psq_pkg::*;
#(
    parameter bit          HAS_RESET = 1'b1,
    parameter int unsigned PRE_CYC   = 20000,
    parameter int unsigned POST_CYC  = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_req_i,
    input  logic disable_req_i,
    output logic clk_en_o,
    output logic periph_rst_o,
    output logic busy_o,
    output logic done_o,
    output logic enabled_o
);
    localparam logic RST_INIT = HAS_RESET;

    seq_state_t state_q, state_d;
    logic clk_en_q, prst_q, done_q;
    logic pend_dis;
    logic pre_exp, post_exp;
    logic in_idle, take_dis, take_en, is_on, run_seq;
    logic pre_start, post_start, seq_end;

    assign in_idle    = (state_q == SEQ_IDLE);
    assign is_on      = clk_en_q && !prst_q;
    assign take_dis   = in_idle && (disable_req_i || pend_dis);
    assign take_en    = in_idle && !take_dis && enable_req_i;
    assign run_seq    = take_en && !is_on && HAS_RESET;
    assign pre_start  = run_seq;
    assign post_start = (state_q == SEQ_PRE) && pre_exp;
    assign seq_end    = (state_q == SEQ_POST) && post_exp;

    psq_pend_hold u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (!in_idle && disable_req_i),
        .clr_i  (take_dis),
        .pend_o (pend_dis)
    );

    generate
        if (HAS_RESET) begin : g_timers
            psq_wait_timer #(.LEN(PRE_CYC)) u_pre (
                .clk       (clk),
                .rst_n     (rst_n),
                .start_i   (pre_start),
                .expired_o (pre_exp)
            );
            psq_wait_timer #(.LEN(POST_CYC)) u_post (
                .clk       (clk),
                .rst_n     (rst_n),
                .start_i   (post_start),
                .expired_o (post_exp)
            );
        end else begin : g_no_timers
            assign pre_exp  = 1'b0;
            assign post_exp = 1'b0;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (run_seq)    state_d = SEQ_PRE;
            SEQ_PRE:  if (post_start) state_d = SEQ_POST;
            SEQ_POST: if (seq_end)    state_d = SEQ_IDLE;
            default:                  state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            prst_q   <= RST_INIT;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (take_dis) begin
                        clk_en_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else if (take_en) begin
                        if (is_on) begin
                            done_q <= 1'b1;
                        end else if (HAS_RESET) begin
                            prst_q <= 1'b1;
                        end else begin
                            clk_en_q <= 1'b1;
                            done_q   <= 1'b1;
                        end
                    end
                end
                SEQ_PRE: begin
                    if (post_start) clk_en_q <= 1'b1;
                end
                SEQ_POST: begin
                    if (seq_end) begin
                        prst_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign clk_en_o     = clk_en_q;
    assign periph_rst_o = prst_q;
    assign busy_o       = !in_idle;
    assign done_o       = done_q;
    assign enabled_o    = clk_en_q && !prst_q;

endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
    parameter bit          HAS_RESET = 1'b1,
    parameter int unsigned POST_CYC  = 2000000
) (
    input logic clk,
    input logic rst_n,
    input logic clk_en_o,
    input logic periph_rst_o,
    input logic busy_o,
    input logic done_o
);
    localparam int unsigned PW = $clog2(POST_CYC + 2);

    logic [PW-1:0] under_rst_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       under_rst_cnt <= '0;
        else if (clk_en_o && periph_rst_o) under_rst_cnt <= under_rst_cnt + 1'b1;
        else                               under_rst_cnt <= '0;
    end

    AST_CLK_STARTS_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RESET && $rose(clk_en_o)) |-> periph_rst_o); // R2

    AST_RST_RELEASE_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst_o) |-> clk_en_o); // R2

    AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst_o) |-> (under_rst_cnt == PW'(POST_CYC))); // R2

    AST_DISABLE_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> $stable(periph_rst_o)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3

    AST_BUSY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> periph_rst_o); // R2

    AST_NO_LINE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_RESET |-> (!periph_rst_o && !busy_o)); // R9

endmodule

bind periph_power_seq psq_checker #(
    .HAS_RESET (HAS_RESET),
    .POST_CYC  (POST_CYC)
) u_psq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_o     (clk_en_o),
    .periph_rst_o (periph_rst_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/periph_power_seq_tb_top.sv
`timescale 1ns/1ps
module periph_power_seq_tb_top;
    localparam int PRE  = 4;
    localparam int POST = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, dis_a = 1'b0, en_b = 1'b0, dis_b = 1'b0;
    logic clk_a, rst_a, busy_a, done_a, on_a;
    logic clk_b, rst_b, busy_b, done_b, on_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    periph_power_seq #(.HAS_RESET(1'b1), .PRE_CYC(PRE), .POST_CYC(POST)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable_req_i(en_a), .disable_req_i(dis_a),
        .clk_en_o(clk_a), .periph_rst_o(rst_a), .busy_o(busy_a),
        .done_o(done_a), .enabled_o(on_a));

    periph_power_seq #(.HAS_RESET(1'b0), .PRE_CYC(PRE), .POST_CYC(POST)) dut_nr (
        .clk(clk), .rst_n(rst_n), .enable_req_i(en_b), .disable_req_i(dis_b),
        .clk_en_o(clk_b), .periph_rst_o(rst_b), .busy_o(busy_b),
        .done_o(done_b), .enabled_o(on_b));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset_state();
        chk("R1", "clk_en", clk_a, 0);
        chk("R1", "rst", rst_a, 1);
        chk("R1", "busy", busy_a, 0);
        chk("R1", "done", done_a, 0);
        chk("R1", "enabled", on_a, 0);
        chk("R9", "no-line rst", rst_b, 0);
        chk("R9", "no-line clk", clk_b, 0);
    endtask

    // Full power-up sequence; optionally injects an enable or disable at cycle 2.
    task automatic t_sequence(input bit inj_en, input bit inj_dis);
        int clk_on_at = -1;
        int rst_off_at = -1;
        int busy_cnt = 0;
        int done_cnt = 0;
        int last = PRE + POST + 2;
        @(negedge clk); en_a = 1'b1;
        @(negedge clk); en_a = 1'b0;
        chk("R2", "rst at accept", rst_a, 1);
        chk("R2", "clk at accept", clk_a, 0);
        for (int cyc = 0; cyc <= last; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (clk_a && clk_on_at < 0) clk_on_at = cyc;
            if (!rst_a && rst_off_at < 0) rst_off_at = cyc;
            if (busy_a) busy_cnt++;
            if (done_a) done_cnt++;
            if (cyc == PRE + POST - 1) begin
                chk("R4", "enabled under reset", on_a, 0);
                chk("R2", "clk during settle", clk_a, 1);
            end
            if (cyc == PRE + POST) begin
                chk("R3", "done at release", done_a, 1);
                chk("R3", "busy at release", busy_a, 0);
                chk("R4", "enabled after release", on_a, 1);
            end
            if (cyc == PRE + POST + 1) begin
                chk(inj_dis ? "R8" : "R3", "clk after end", clk_a, inj_dis ? 0 : 1);
                chk(inj_dis ? "R8" : "R3", "done after end", done_a, inj_dis ? 1 : 0);
                chk(inj_dis ? "R8" : "R6", "rst after end", rst_a, 0);
            end
            en_a  = (cyc == 2) && inj_en;
            dis_a = (cyc == 2) && inj_dis;
        end
        chk("R2", "clock start cycle", clk_on_at, PRE);
        chk("R2", "reset release cycle", rst_off_at, PRE + POST);
        chk("R3", "busy cycles", busy_cnt, PRE + POST);
        chk(inj_dis ? "R8" : "R7", "done pulses", done_cnt, inj_dis ? 2 : 1);
        if (inj_en) chk("R7", "no second sequence", busy_a, 0);
    endtask

    task automatic t_already_on();
        @(negedge clk); en_a = 1'b1;
        @(negedge clk); en_a = 1'b0;
        chk("R5", "done", done_a, 1);
        chk("R5", "busy", busy_a, 0);
        chk("R5", "clk", clk_a, 1);
        chk("R5", "rst", rst_a, 0);
        @(negedge clk);
        chk("R5", "busy later", busy_a, 0);
        chk("R5", "done later", done_a, 0);
    endtask

    task automatic t_disable();
        @(negedge clk); dis_a = 1'b1;
        @(negedge clk); dis_a = 1'b0;
        chk("R6", "clk off", clk_a, 0);
        chk("R6", "rst unchanged", rst_a, 0);
        chk("R6", "done", done_a, 1);
        chk("R4", "enabled off", on_a, 0);
    endtask

    task automatic t_both_req();
        @(negedge clk); en_a = 1'b1; dis_a = 1'b1;
        @(negedge clk); en_a = 1'b0; dis_a = 1'b0;
        chk("R10", "clk off", clk_a, 0);
        chk("R10", "done", done_a, 1);
        chk("R10", "no sequence", busy_a, 0);
        @(negedge clk);
        chk("R10", "still idle", busy_a, 0);
        chk("R10", "rst", rst_a, 0);
    endtask

    task automatic t_no_line();
        @(negedge clk); en_b = 1'b1;
        @(negedge clk); en_b = 1'b0;
        chk("R9", "clk on", clk_b, 1);
        chk("R9", "done", done_b, 1);
        chk("R9", "busy", busy_b, 0);
        chk("R9", "rst", rst_b, 0);
        chk("R9", "enabled", on_b, 1);
        @(negedge clk); dis_b = 1'b1;
        @(negedge clk); dis_b = 1'b0;
        chk("R9", "clk off", clk_b, 0);
        chk("R9", "rst after disable", rst_b, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_sequence(1'b0, 1'b0);
        t_already_on();
        t_disable();
        t_sequence(1'b1, 1'b0);
        t_disable();
        t_sequence(1'b0, 1'b1);
        t_sequence(1'b0, 1'b0);
        t_both_req();
        t_no_line();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule